// File: doc/BRIEF.md
# I2C Register Target with Row-Limited Page Writes and Deferred Commit

This block is an I2C target that serves a small byte-addressed register map to a bus master. SCL and SDA are oversampled by the system clock through two-stage synchronisers, and the block pulls SDA low through an open-drain enable. The first byte after a START selects the device and the transfer direction. A write then takes a pointer byte, followed by data bytes that land at the pointer. The pointer advances after each data byte but stays inside the current 8-byte row. A read returns bytes from the pointer onward and walks the whole map.

Every accepted data byte goes into the register array. When the load-enable input is high, it also goes into the live copy that drives the outputs. The nonvolatile store is modelled as a third array. After a STOP, the bytes touched by the write transaction are copied into it. The block raises a busy flag for a parameterised number of clock cycles while this happens. During that time it refuses its own address, so the master can poll with address bytes until it gets an acknowledge.

Top module: `i2cpw_top`

## Requirements
- R1: After reset, sdaOe is low, busy is low, and every byte of the register, live and nonvolatile arrays is zero.
- R2: The first byte after a START is compared in bits 7:1 with {ADDR_HI, a0Strap} (C0h/C1h with the strap low, C2h/C3h with it high). Bit 0 set to 0 selects a write and set to 1 selects a read. On a match the block pulls SDA low during the ninth clock.
- R3: After a non-matching address byte the block never drives SDA and changes no state until the next START.
- R4: In a write, the byte after the address loads the pointer (its low bits index the map). Each following data byte is acknowledged and stored at the pointer, and then the pointer advances.
- R5: Write auto-increment wraps inside the 8-byte row: address 8k+7 is followed by 8k.
- R6: With loadEn high, a data byte reaches the live output when it is acknowledged. With loadEn low, the live output keeps its value, but the register array, readback and commit still take the byte.
- R7: A STOP that ends a write which stored at least one data byte starts a commit, and the nonvolatile output takes the written bytes when busy falls. A transaction with no data byte, or one cut off by a STOP in the middle of a byte, starts no commit.
- R8: busy stays high for exactly COMMIT_CYCLES clock cycles per commit.
- R9: While busy is high, the block does not acknowledge its own address byte. Once busy falls, it acknowledges it again.
- R10: A read sends the byte at the pointer MSB first and advances the pointer by one across the whole map, wrapping only at the end of the map. A master ACK asks for the next byte. After a master NACK the block leaves SDA released.
- R11: A STOP at any point returns the block to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock level as seen on the wire |
| sdaIn | input | 1 | Bus data level as seen on the wire |
| a0Strap | input | 1 | Address strap, becomes address bit 0 (byte bit 1) |
| loadEn | input | 1 | Lets written bytes reach the live output |
| sdaOe | output | 1 | High pulls SDA low |
| busy | output | 1 | Commit in progress |
| liveFlat | output | DEPTH*8 | Live register copy, byte i at bits 8i+7:8i |
| nvFlat | output | DEPTH*8 | Nonvolatile store model, same layout |

## Verification
The hardest case to reach is the refusal of the block's own address during a commit. The address byte has to finish while the commit counter is still running. To get there, the bench starts an address-only poll at once after a committing STOP, with the commit time set longer than one address byte. It then repeats the poll until an acknowledge arrives, which shows both the refusal and the recovery. The other hard cases are a write that runs past the end of its row and a read that crosses a row boundary and the end of the map. Both are reached with pointer bytes placed a few addresses before those boundaries.

// File: rtl/i2cpw_pkg.sv
package i2cpw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_IGNORE
  } bus_state_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_PTR, PH_DATA, PH_READ
  } phase_e;

  typedef struct packed {
    logic       ptrLoad;
    logic       dataWr;
    logic       rdAdvance;
    logic       stopSeen;
    logic [7:0] byteVal;
  } ctrl_strobe_t;

endpackage

// File: rtl/i2cpw_ctrl.sv
module i2cpw_ctrl
  import i2cpw_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b110000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclIn,
  input  logic         sdaIn,
  input  logic         a0Strap,
  input  logic         busy,
  input  logic [7:0]   rdData,
  output ctrl_strobe_t stb,
  output logic         sdaOe
);

  logic [1:0] sclSy, sdaSy;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS;
  logic       sclRise, sclFall, startC, stopC;

  bus_state_e state;
  phase_e     phase;
  logic [3:0] cnt;
  logic [7:0] rxSh, txSh;
  logic       mAck;

  assign sclS    = sclSy[1];
  assign sdaS    = sdaSy[1];
  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startC  = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopC   = sclS & sclPrev & ~sdaPrev & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSy   <= 2'b11;
      sdaSy   <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSy   <= {sclSy[0], sclIn};
      sdaSy   <= {sdaSy[0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= PH_ADDR;
      cnt   <= '0;
      rxSh  <= '0;
      txSh  <= '0;
      mAck  <= 1'b0;
      stb   <= '0;
    end else begin
      stb <= '0;
      if (startC) begin
        state <= ST_RX;
        phase <= PH_ADDR;
        cnt   <= '0;
      end else if (stopC) begin
        state        <= ST_IDLE;
        stb.stopSeen <= 1'b1;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise && cnt != 4'd8) begin
              rxSh <= {rxSh[6:0], sdaS};
              cnt  <= cnt + 4'd1;
            end else if (sclFall && cnt == 4'd8) begin
              case (phase)
                PH_ADDR: begin
                  if (rxSh[7:1] == {ADDR_HI, a0Strap} && !busy) begin
                    state <= ST_ACK;
                    phase <= rxSh[0] ? PH_READ : PH_PTR;
                  end else begin
                    state <= ST_IGNORE;
                  end
                end
                PH_PTR: begin
                  stb.ptrLoad <= 1'b1;
                  stb.byteVal <= rxSh;
                  phase       <= PH_DATA;
                  state       <= ST_ACK;
                end
                PH_DATA: begin
                  stb.dataWr  <= 1'b1;
                  stb.byteVal <= rxSh;
                  state       <= ST_ACK;
                end
                default: state <= ST_IGNORE;
              endcase
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              cnt <= '0;
              if (phase == PH_READ) begin
                txSh          <= rdData;
                stb.rdAdvance <= 1'b1;
                state         <= ST_TX;
              end else begin
                state <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (sclFall) begin
              if (cnt == 4'd7) begin
                state <= ST_MACK;
              end else begin
                txSh <= {txSh[6:0], 1'b0};
                cnt  <= cnt + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (sclRise) begin
              mAck <= ~sdaS;
            end else if (sclFall) begin
              if (mAck) begin
                txSh          <= rdData;
                stb.rdAdvance <= 1'b1;
                cnt           <= '0;
                state         <= ST_TX;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaOe = (state == ST_ACK) || (state == ST_TX && !txSh[7]);

  // R9: own address while a commit runs leads to the ignore state, no ACK
  a_r9_nack_busy: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RX && phase == PH_ADDR && cnt == 4'd8 && sclFall && busy && !startC && !stopC)
      |=> (state == ST_IGNORE));

endmodule

// File: rtl/i2cpw_data.sv
module i2cpw_data
  import i2cpw_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int ROW           = 8,
  parameter int COMMIT_CYCLES = 20000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadEn,
  input  ctrl_strobe_t       stb,
  output logic [7:0]         rdData,
  output logic               busy,
  output logic [DEPTH*8-1:0] liveFlat,
  output logic [DEPTH*8-1:0] nvFlat
);

  localparam int PW = $clog2(DEPTH);
  localparam int RW = $clog2(ROW);
  localparam int CW = $clog2(COMMIT_CYCLES + 1);

  logic [7:0]       regs [DEPTH];
  logic [7:0]       live [DEPTH];
  logic [7:0]       nv   [DEPTH];
  logic [DEPTH-1:0] dirty;
  logic [PW-1:0]    ptr;
  logic [CW-1:0]    busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      dirty   <= '0;
      busyCnt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        regs[i] <= '0;
        live[i] <= '0;
        nv[i]   <= '0;
      end
    end else begin
      if (stb.ptrLoad) begin
        ptr <= stb.byteVal[PW-1:0];
      end else if (stb.dataWr) begin
        regs[ptr]  <= stb.byteVal;
        if (loadEn) live[ptr] <= stb.byteVal;
        dirty[ptr] <= 1'b1;
        ptr        <= {ptr[PW-1:RW], ptr[RW-1:0] + RW'(1)};
      end else if (stb.rdAdvance) begin
        ptr <= ptr + PW'(1);
      end

      if (stb.stopSeen && busyCnt == '0 && |dirty) begin
        busyCnt <= CW'(COMMIT_CYCLES);
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - CW'(1);
      end

      if (busyCnt == CW'(1)) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (dirty[i]) nv[i] <= regs[i];
        end
        dirty <= '0;
      end
    end
  end

  assign rdData = regs[ptr];
  assign busy   = (busyCnt != '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign liveFlat[g*8 +: 8] = live[g];
    assign nvFlat[g*8 +: 8]   = nv[g];
  end

  // R5: a data write never moves the pointer out of its row
  a_r5_row_wrap: assert property (@(posedge clk) disable iff (!rstN)
    stb.dataWr |=> (ptr[PW-1:RW] == $past(ptr[PW-1:RW])));

  // R6: with loadEn low the live copy holds
  a_r6_live_hold: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> $stable(liveFlat));

  // R7: the nonvolatile copy changes only as a commit ends
  a_r7_nv_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(nvFlat));

  // R7: a commit begins only after a STOP from the control
  a_r7_commit_on_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stb.stopSeen));

endmodule

// File: rtl/i2cpw_top.sv
module i2cpw_top
  import i2cpw_pkg::*;
#(
  parameter int         DEPTH         = 16,
  parameter int         ROW           = 8,
  parameter int         COMMIT_CYCLES = 20000,
  parameter logic [5:0] ADDR_HI       = 6'b110000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic               a0Strap,
  input  logic               loadEn,
  output logic               sdaOe,
  output logic               busy,
  output logic [DEPTH*8-1:0] liveFlat,
  output logic [DEPTH*8-1:0] nvFlat
);

  ctrl_strobe_t stb;
  logic [7:0]   rdData;

  i2cpw_ctrl #(.ADDR_HI(ADDR_HI)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .a0Strap(a0Strap), .busy(busy), .rdData(rdData),
    .stb(stb), .sdaOe(sdaOe)
  );

  i2cpw_data #(.DEPTH(DEPTH), .ROW(ROW), .COMMIT_CYCLES(COMMIT_CYCLES)) u_data (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .stb(stb),
    .rdData(rdData), .busy(busy), .liveFlat(liveFlat), .nvFlat(nvFlat)
  );

endmodule

// File: tb/tb_i2cpw_top.sv
module tb_i2cpw_top;

  localparam int DEPTH  = 16;
  localparam int COMMIT = 400;
  localparam int Q      = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic a0Strap = 1'b0, loadEn = 1'b1;
  logic sdaOe, busy;
  logic [DEPTH*8-1:0] liveFlat, nvFlat;
  logic sdaLine;

  assign sdaLine = sdaM & ~sdaOe;

  always #10 clk = ~clk;

  i2cpw_top #(.DEPTH(DEPTH), .ROW(8), .COMMIT_CYCLES(COMMIT)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .a0Strap(a0Strap), .loadEn(loadEn), .sdaOe(sdaOe), .busy(busy),
    .liveFlat(liveFlat), .nvFlat(nvFlat)
  );

  int total = 0, bad = 0;
  logic [7:0] mRegs [DEPTH];
  logic [7:0] mLive [DEPTH];
  logic [7:0] mNv   [DEPTH];
  bit   mDirty [DEPTH];
  int   mPtr = 0;
  bit   quiet = 1'b0;
  bit   sawDrive = 1'b0;
  int   busyRun = 0;
  bit   busyPrev = 1'b0;
  logic [7:0] txq [$];
  logic [7:0] rxq [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model compared on every clock while the bus is quiet
  always @(negedge clk) begin
    if (rstN) begin
      if (sdaOe) sawDrive = 1'b1;
      if (busy) busyRun++;
      if (busyPrev && !busy) begin
        chk(busyRun == COMMIT, "R8 busy length", busyRun, COMMIT);
        busyRun = 0;
      end
      busyPrev = busy;
      if (quiet) begin
        chk(!sdaOe, "R11 idle release", sdaOe, 0);
        for (int i = 0; i < DEPTH; i++) begin
          if (liveFlat[i*8 +: 8] !== mLive[i])
            chk(1'b0, "R6 live copy", liveFlat[i*8 +: 8], mLive[i]);
          if (!busy && nvFlat[i*8 +: 8] !== mNv[i])
            chk(1'b0, "R7 nv copy", nvFlat[i*8 +: 8], mNv[i]);
        end
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; wq(Q); sclM = 1'b1; wq(Q);
    sdaM = 1'b0; wq(Q); sclM = 1'b0; wq(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; wq(Q); sclM = 1'b1; wq(Q);
    sdaM = 1'b1; wq(2*Q);
  endtask

  task automatic wrBit(input bit b);
    sdaM = b; wq(Q); sclM = 1'b1; wq(2*Q); sclM = 1'b0; wq(Q);
  endtask

  task automatic rdBit(output bit b);
    sdaM = 1'b1; wq(Q); sclM = 1'b1; wq(Q);
    b = sdaLine; wq(Q); sclM = 1'b0; wq(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) wrBit(v[i]);
    rdBit(b);
    ack = ~b;
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin rdBit(b); v[i] = b; end
    wrBit(~ackIt);
  endtask

  // STOP in the model: commit when data was stored
  task automatic modelStop();
    for (int i = 0; i < DEPTH; i++) begin
      if (mDirty[i]) mNv[i] = mRegs[i];
      mDirty[i] = 1'b0;
    end
  endtask

  task automatic endTxn();
    busStop();
    modelStop();
    quiet = 1'b1;
  endtask

  task automatic writeTxn(input logic [7:0] addr, input logic [7:0] p, input string req);
    bit ack;
    quiet = 1'b0;
    busStart();
    sendByte(addr, ack);
    chk(ack, "R2 address ack", ack, 1);
    sendByte(p, ack);
    chk(ack, "R4 pointer ack", ack, 1);
    mPtr = p % DEPTH;
    foreach (txq[k]) begin
      sendByte(txq[k], ack);
      chk(ack, req, ack, 1);
      mRegs[mPtr] = txq[k];
      if (loadEn) mLive[mPtr] = txq[k];
      mDirty[mPtr] = 1'b1;
      mPtr = (mPtr & ~7) | ((mPtr + 1) & 7);
    end
    endTxn();
  endtask

  task automatic readTxn(input logic [7:0] addrW, input logic [7:0] p, input int n);
    bit ack;
    logic [7:0] v;
    quiet = 1'b0;
    busStart();
    sendByte(addrW, ack);
    sendByte(p, ack);
    mPtr = p % DEPTH;
    busStart();
    sendByte(addrW | 8'h01, ack);
    chk(ack, "R2 read address ack", ack, 1);
    rxq.delete();
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, v);
      rxq.push_back(v);
      chk(v == mRegs[mPtr], "R10 read data", v, mRegs[mPtr]);
      mPtr = (mPtr + 1) % DEPTH;
    end
    sawDrive = 1'b0;
    wq(4*Q);
    chk(!sawDrive, "R10 released after NACK", sawDrive, 0);
    endTxn();
  endtask

  task automatic waitIdle();
    while (busy) @(posedge clk);
    wq(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ack;
    int polls;
    int nacks;
    for (int i = 0; i < DEPTH; i++) begin
      mRegs[i] = 8'h00; mLive[i] = 8'h00; mNv[i] = 8'h00; mDirty[i] = 1'b0;
    end
    wq(5);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!sdaOe && !busy, "R1 reset outputs", {sdaOe, busy}, 0);
    chk(liveFlat == '0 && nvFlat == '0, "R1 reset arrays", liveFlat[31:0], 0);
    quiet = 1'b1;

    // R2 R4 basic write, then R9 acknowledge polling
    txq = '{8'h11, 8'h22, 8'h33};
    writeTxn(8'hC0, 8'h02, "R4 data ack");
    chk(busy, "R7 commit started", busy, 1);
    quiet = 1'b0;
    polls = 0; nacks = 0;
    do begin
      busStart();
      sendByte(8'hC0, ack);
      busStop();
      polls++;
      if (!ack) nacks++;
    end while (!ack && polls < 20);
    chk(nacks >= 1, "R9 NACK while busy", nacks, 1);
    chk(ack, "R9 ACK after busy", ack, 1);
    chk(!busy, "R7 address-only write no commit", busy, 0);
    quiet = 1'b1;
    wq(10);
    chk(nvFlat[3*8 +: 8] == 8'h22, "R7 nv after commit", nvFlat[3*8 +: 8], 8'h22);

    // R5 row wrap
    txq = '{8'hA1, 8'hA2, 8'hA3, 8'hA4};
    writeTxn(8'hC0, 8'h06, "R5 wrap data ack");
    waitIdle();
    chk(liveFlat[0 +: 8] == 8'hA3, "R5 wrap to row start", liveFlat[0 +: 8], 8'hA3);
    chk(liveFlat[8*8 +: 8] == 8'h00, "R5 next row untouched", liveFlat[8*8 +: 8], 0);

    // R10 read across a row boundary and the end of the map
    readTxn(8'hC0, 8'h06, 4);
    chk(!busy, "R7 read no commit", busy, 0);
    readTxn(8'hC0, 8'h0F, 2);

    // R3 mismatching address ignored
    quiet = 1'b0;
    busStart();
    sawDrive = 1'b0;
    sendByte(8'hC2, ack);
    chk(!ack, "R3 wrong address NACK", ack, 0);
    sendByte(8'h05, ack);
    sendByte(8'h77, ack);
    chk(!sawDrive, "R3 SDA never driven", sawDrive, 0);
    endTxn();
    wq(10);
    chk(!busy, "R3 no commit", busy, 0);

    // R2 strap high moves address
    a0Strap = 1'b1;
    txq = '{8'h5A};
    writeTxn(8'hC2, 8'h0A, "R2 strap data ack");
    waitIdle();
    quiet = 1'b0;
    busStart();
    sendByte(8'hC0, ack);
    chk(!ack, "R3 old address refused", ack, 0);
    endTxn();
    a0Strap = 1'b0;

    // R6 load disabled
    loadEn = 1'b0;
    txq = '{8'hC3};
    writeTxn(8'hC0, 8'h0C, "R6 data ack");
    chk(liveFlat[12*8 +: 8] == 8'h00, "R6 live held", liveFlat[12*8 +: 8], 0);
    waitIdle();
    chk(nvFlat[12*8 +: 8] == 8'hC3, "R6 nv still commits", nvFlat[12*8 +: 8], 8'hC3);
    readTxn(8'hC0, 8'h0C, 1);
    chk(rxq[0] == 8'hC3, "R6 readback", rxq[0], 8'hC3);
    loadEn = 1'b1;

    // R5 ten bytes into one row
    txq = {};
    for (int k = 0; k < 10; k++) txq.push_back(8'(8'h40 + k));
    writeTxn(8'hC0, 8'h18, "R5 long write ack");
    waitIdle();
    chk(liveFlat[8*8 +: 8] == 8'h48, "R5 overwrite row start", liveFlat[8*8 +: 8], 8'h48);

    // R11 STOP inside a data byte
    quiet = 1'b0;
    busStart();
    sendByte(8'hC0, ack);
    sendByte(8'h04, ack);
    wrBit(1'b1); wrBit(1'b0); wrBit(1'b1);
    endTxn();
    wq(10);
    chk(!busy, "R11 cut byte no commit", busy, 0);
    txq = '{8'h99};
    writeTxn(8'hC0, 8'h05, "R11 works after cut");
    waitIdle();
    wq(10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule